// File: doc/BRIEF.md
# I2C Master Status and Interrupt Unit

This block holds the read-only status word of an I2C master controller and drives its single interrupt request. The master engine and the bus monitor feed it one-cycle event pulses (START seen, STOP seen, arbitration lost, address not acknowledged, data not acknowledged, transfer finished, receive FIFO push, address-plus-write phase sent) and a few levels (receive FIFO full, master busy). The block turns these into sticky or per-cycle flags. It also follows the push and pop strobes of a two-entry transmit FIFO and reports that FIFO's fill level as a 2-bit code.

Two state machines carry the block's sequential behaviour. The bus tracker has the states BUS_FREE and BUS_HELD. It moves from BUS_FREE to BUS_HELD on a START and returns to BUS_FREE on a STOP. A STOP in the same cycle as a START wins. The level tracker has four states, and each state's encoding is the level code it reports: LVL_EMPTY (00), LVL_ONE_PUSHED (01), LVL_ONE_POPPED (10) and LVL_FULL (11).
- A push alone moves EMPTY to ONE_PUSHED, and moves ONE_PUSHED or ONE_POPPED to FULL.
- A pop alone moves FULL to ONE_POPPED, and moves ONE_PUSHED or ONE_POPPED to EMPTY.
- A push and a pop in the same cycle leave every state where it is.
- A pop in EMPTY and a push in FULL also leave the state unchanged.

Per-source enable bits from a control register gate the interrupt sources. The enabled sources are ORed into the interrupt line. A status read strobe clears the transfer-complete flag.

Top module: `i2c_mstat_unit`

## Requirements
- R1: After reset the status word is 0x0000 and `irq` is low. Bits 15 to 11 always read 0.
- R2: Bit 10 (bus busy) becomes 1 the cycle after `ev_start` and 0 the cycle after `ev_stop`. When both pulse in the same cycle, the bit becomes 0.
- R3: Bit 9 (receive overflow) is 1 for exactly the cycle after a cycle in which `rx_push` and `rx_full` are both high. Otherwise it is 0.
- R4: Bit 8 (transfer complete) becomes 1 the cycle after `ev_xfer_done` and holds. It clears the cycle after `stat_rd`, unless `ev_xfer_done` is high in that same cycle.
- R5: Bit 7 (data NACK), bit 5 (arbitration lost) and bit 4 (address NACK) each become 1 the cycle after their event pulse and hold until the cycle after an `ev_start`. Their own event in the same cycle as `ev_start` wins.
- R6: Bit 6 (master busy) equals the previous cycle's `mst_busy_in`, but is forced to 0 the cycle after `ev_arb_lost`.
- R7: Bit 3 (receive request) is 1 for exactly the cycle after a cycle with `rx_push` high.
- R8: Bit 2 (transmit request) is 1 when an `addr_wr_sent` pulse has arrived since the last `ev_stop` and bits 1:0 are not 11. If `addr_wr_sent` and `ev_stop` pulse in the same cycle, the flag stays set.
- R9: Bits 1:0 report the level one cycle after each strobe. The codes are 00 for empty, 01 after a push into an empty FIFO, 10 after a pop from a full FIFO, and 11 for full. A push alone from 01 or 10 gives 11, and a pop alone from 01 or 10 gives 00.
- R10: A cycle with both `tx_push` and `tx_pop` leaves bits 1:0 unchanged. So do a pop at code 00 and a push at code 11.
- R11: `irq` is high exactly when at least one of these holds: `ie_xfer` and bit 8; `ie_nack` and bit 7 or bit 4; `ie_arb` and bit 5; `ie_rx` and bit 3; `ie_tx` and bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | START detected on the bus (pulse) |
| ev_stop | input | 1 | STOP detected on the bus (pulse) |
| ev_arb_lost | input | 1 | Arbitration lost (pulse) |
| ev_addr_nack | input | 1 | Address not acknowledged (pulse) |
| ev_data_nack | input | 1 | Written data byte not acknowledged (pulse) |
| ev_xfer_done | input | 1 | Transaction finished (pulse) |
| rx_push | input | 1 | Byte written into the receive FIFO |
| rx_full | input | 1 | Receive FIFO already full |
| tx_push | input | 1 | Byte written into the transmit FIFO |
| tx_pop | input | 1 | Byte taken from the transmit FIFO |
| addr_wr_sent | input | 1 | Address with write direction sent (pulse) |
| mst_busy_in | input | 1 | Master engine is processing a transaction |
| stat_rd | input | 1 | Status word is being read |
| ie_xfer | input | 1 | Transfer-complete interrupt enable |
| ie_nack | input | 1 | NACK interrupt enable |
| ie_arb | input | 1 | Arbitration-lost interrupt enable |
| ie_rx | input | 1 | Receive-request interrupt enable |
| ie_tx | input | 1 | Transmit-request interrupt enable |
| stat_word | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
A short directed opening first fills the transmit FIFO, pushes into it while full, drains it and pops it while empty. This shows apart the two one-byte codes and the ignored strobes. Long runs of sparse random pulses follow, mixed with dense push/pop traffic. Coincident START/STOP, event-plus-clear and push-plus-pop cycles in this traffic separate the priority choices of R2, R4, R5 and R10. Enables that toggle on their own confirm that each interrupt source is gated only by its own enable.

// File: rtl/i2c_mstat_pkg.sv
package i2c_mstat_pkg;

    localparam int STAT_W = 16;
    localparam int LVL_W  = 2;

    localparam int B_BUSBUSY = 10;
    localparam int B_RXOVF   = 9;
    localparam int B_DONE    = 8;
    localparam int B_DNACK   = 7;
    localparam int B_MBUSY   = 6;
    localparam int B_ARB     = 5;
    localparam int B_ANACK   = 4;
    localparam int B_RXREQ   = 3;
    localparam int B_TXREQ   = 2;
    localparam int B_RSV_LO  = 11;

    localparam int N_IRQ_SRC = 5;

    typedef enum logic [LVL_W-1:0] {
        LVL_EMPTY      = 2'b00,
        LVL_ONE_PUSHED = 2'b01,
        LVL_ONE_POPPED = 2'b10,
        LVL_FULL       = 2'b11
    } lvl_state_t;

    typedef enum logic {
        BUS_FREE = 1'b0,
        BUS_HELD = 1'b1
    } bus_state_t;

endpackage

// File: rtl/i2c_mstat_busmon.sv
module i2c_mstat_busmon
    import i2c_mstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_start,
    input  logic ev_stop,
    output logic bus_busy
);

    bus_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_FREE: if (ev_start && !ev_stop) state_d = BUS_HELD;
            BUS_HELD: if (ev_stop)              state_d = BUS_FREE;
            default:                            state_d = BUS_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        bus_busy = (state_q == BUS_HELD);
    end

endmodule

// File: rtl/i2c_mstat_txlvl.sv
module i2c_mstat_txlvl
    import i2c_mstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_push,
    input  logic             tx_pop,
    output logic [LVL_W-1:0] lvl_code,
    output logic             lvl_full
);

    lvl_state_t state_q, state_d;
    logic       push_only, pop_only;

    assign push_only = tx_push && !tx_pop;
    assign pop_only  = tx_pop && !tx_push;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_EMPTY: begin
                if (push_only) state_d = LVL_ONE_PUSHED;
            end
            LVL_ONE_PUSHED, LVL_ONE_POPPED: begin
                if (push_only)     state_d = LVL_FULL;
                else if (pop_only) state_d = LVL_EMPTY;
            end
            LVL_FULL: begin
                if (pop_only) state_d = LVL_ONE_POPPED;
            end
            default: state_d = LVL_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        lvl_code = state_q;
        lvl_full = (state_q == LVL_FULL);
    end

endmodule

// File: rtl/i2c_mstat_flags.sv
module i2c_mstat_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_start,
    input  logic ev_stop,
    input  logic ev_arb_lost,
    input  logic ev_addr_nack,
    input  logic ev_data_nack,
    input  logic ev_xfer_done,
    input  logic rx_push,
    input  logic rx_full,
    input  logic addr_wr_sent,
    input  logic mst_busy_in,
    input  logic stat_rd,
    input  logic lvl_full,
    output logic f_rxovf,
    output logic f_done,
    output logic f_dnack,
    output logic f_mbusy,
    output logic f_arb,
    output logic f_anack,
    output logic f_rxreq,
    output logic f_txreq
);

    logic aw_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_rxovf   <= 1'b0;
            f_done    <= 1'b0;
            f_dnack   <= 1'b0;
            f_mbusy   <= 1'b0;
            f_arb     <= 1'b0;
            f_anack   <= 1'b0;
            f_rxreq   <= 1'b0;
            aw_seen_q <= 1'b0;
        end else begin
            f_rxovf <= rx_push && rx_full;
            f_rxreq <= rx_push;
            f_mbusy <= mst_busy_in && !ev_arb_lost;

            if (ev_xfer_done) f_done <= 1'b1;
            else if (stat_rd) f_done <= 1'b0;

            if (ev_data_nack)  f_dnack <= 1'b1;
            else if (ev_start) f_dnack <= 1'b0;

            if (ev_addr_nack)  f_anack <= 1'b1;
            else if (ev_start) f_anack <= 1'b0;

            if (ev_arb_lost)   f_arb <= 1'b1;
            else if (ev_start) f_arb <= 1'b0;

            if (addr_wr_sent) aw_seen_q <= 1'b1;
            else if (ev_stop) aw_seen_q <= 1'b0;
        end
    end

    assign f_txreq = aw_seen_q && !lvl_full;

endmodule

// File: rtl/i2c_mstat_irq.sv
module i2c_mstat_irq #(
    parameter int NSRC = 5
) (
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] en,
    output logic            irq
);

    logic [NSRC-1:0] gated;

    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        assign gated[g] = src[g] & en[g];
    end

    assign irq = |gated;

endmodule

// File: rtl/i2c_mstat_unit.sv
module i2c_mstat_unit
    import i2c_mstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_arb_lost,
    input  logic              ev_addr_nack,
    input  logic              ev_data_nack,
    input  logic              ev_xfer_done,
    input  logic              rx_push,
    input  logic              rx_full,
    input  logic              tx_push,
    input  logic              tx_pop,
    input  logic              addr_wr_sent,
    input  logic              mst_busy_in,
    input  logic              stat_rd,
    input  logic              ie_xfer,
    input  logic              ie_nack,
    input  logic              ie_arb,
    input  logic              ie_rx,
    input  logic              ie_tx,
    output logic [STAT_W-1:0] stat_word,
    output logic              irq
);

    logic             bus_busy;
    logic [LVL_W-1:0] lvl_code;
    logic             lvl_full;
    logic             f_rxovf, f_done, f_dnack, f_mbusy;
    logic             f_arb, f_anack, f_rxreq, f_txreq;
    logic [N_IRQ_SRC-1:0] irq_src, irq_en;

    i2c_mstat_busmon u_busmon (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .bus_busy (bus_busy)
    );

    i2c_mstat_txlvl u_txlvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_push  (tx_push),
        .tx_pop   (tx_pop),
        .lvl_code (lvl_code),
        .lvl_full (lvl_full)
    );

    i2c_mstat_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_start     (ev_start),
        .ev_stop      (ev_stop),
        .ev_arb_lost  (ev_arb_lost),
        .ev_addr_nack (ev_addr_nack),
        .ev_data_nack (ev_data_nack),
        .ev_xfer_done (ev_xfer_done),
        .rx_push      (rx_push),
        .rx_full      (rx_full),
        .addr_wr_sent (addr_wr_sent),
        .mst_busy_in  (mst_busy_in),
        .stat_rd      (stat_rd),
        .lvl_full     (lvl_full),
        .f_rxovf      (f_rxovf),
        .f_done       (f_done),
        .f_dnack      (f_dnack),
        .f_mbusy      (f_mbusy),
        .f_arb        (f_arb),
        .f_anack      (f_anack),
        .f_rxreq      (f_rxreq),
        .f_txreq      (f_txreq)
    );

    assign irq_src = {f_done, (f_dnack | f_anack), f_arb, f_rxreq, f_txreq};
    assign irq_en  = {ie_xfer, ie_nack, ie_arb, ie_rx, ie_tx};

    i2c_mstat_irq #(.NSRC(N_IRQ_SRC)) u_irq (
        .src (irq_src),
        .en  (irq_en),
        .irq (irq)
    );

    always_comb begin
        stat_word              = '0;
        stat_word[B_BUSBUSY]   = bus_busy;
        stat_word[B_RXOVF]     = f_rxovf;
        stat_word[B_DONE]      = f_done;
        stat_word[B_DNACK]     = f_dnack;
        stat_word[B_MBUSY]     = f_mbusy;
        stat_word[B_ARB]       = f_arb;
        stat_word[B_ANACK]     = f_anack;
        stat_word[B_RXREQ]     = f_rxreq;
        stat_word[B_TXREQ]     = f_txreq;
        stat_word[LVL_W-1:0]   = lvl_code;
    end

endmodule

// File: rtl/i2c_mstat_chk.sv
module i2c_mstat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_start,
    input logic        ev_stop,
    input logic        ev_addr_nack,
    input logic        rx_push,
    input logic        rx_full,
    input logic        tx_push,
    input logic        tx_pop,
    input logic        stat_rd,
    input logic        ie_rx,
    input logic [15:0] stat_word,
    input logic        irq
);

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[15:11] == 5'd0);

    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !ev_stop) |=> stat_word[10]);

    p_busy_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !stat_word[10]);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_push && rx_full) |=> !stat_word[9]);

    p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[8] && !stat_rd) |=> stat_word[8]);

    p_anack_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_addr_nack |=> stat_word[4]);

    p_txreq_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[1:0] == 2'b11) |-> !stat_word[2]);

    p_first_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[1:0] == 2'b00 && tx_push && !tx_pop) |=> (stat_word[1:0] == 2'b01));

    p_pushpop_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_pop) |=> $stable(stat_word[1:0]));

    p_rx_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_rx && stat_word[3]) |-> irq);

endmodule

bind i2c_mstat_unit i2c_mstat_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_start     (ev_start),
    .ev_stop      (ev_stop),
    .ev_addr_nack (ev_addr_nack),
    .rx_push      (rx_push),
    .rx_full      (rx_full),
    .tx_push      (tx_push),
    .tx_pop       (tx_pop),
    .stat_rd      (stat_rd),
    .ie_rx        (ie_rx),
    .stat_word    (stat_word),
    .irq          (irq)
);

// File: tb/i2c_mstat_unit_bench.sv
`timescale 1ns/1ps
module i2c_mstat_unit_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_start = 0, ev_stop = 0, ev_arb_lost = 0, ev_addr_nack = 0;
    logic ev_data_nack = 0, ev_xfer_done = 0, rx_push = 0, rx_full = 0;
    logic tx_push = 0, tx_pop = 0, addr_wr_sent = 0, mst_busy_in = 0, stat_rd = 0;
    logic ie_xfer = 0, ie_nack = 0, ie_arb = 0, ie_rx = 0, ie_tx = 0;
    logic [15:0] stat_word;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    int m_busy = 0, m_ovf = 0, m_done = 0, m_an = 0, m_dn = 0, m_arb = 0;
    int m_rxq = 0, m_mb = 0, m_aw = 0, m_cnt = 0, m_bypop = 0;
    int m_odd = 0;  // previous cycle had a push+pop, a pop at empty or a push at full

    always #2.5 clk = ~clk;

    i2c_mstat_unit u_i2c_mstat_unit (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_arb_lost(ev_arb_lost), .ev_addr_nack(ev_addr_nack),
        .ev_data_nack(ev_data_nack), .ev_xfer_done(ev_xfer_done),
        .rx_push(rx_push), .rx_full(rx_full), .tx_push(tx_push), .tx_pop(tx_pop),
        .addr_wr_sent(addr_wr_sent), .mst_busy_in(mst_busy_in), .stat_rd(stat_rd),
        .ie_xfer(ie_xfer), .ie_nack(ie_nack), .ie_arb(ie_arb), .ie_rx(ie_rx),
        .ie_tx(ie_tx), .stat_word(stat_word), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_ovf = 0; m_done = 0; m_an = 0; m_dn = 0; m_arb = 0;
            m_rxq = 0; m_mb = 0; m_aw = 0; m_cnt = 0; m_bypop = 0; m_odd = 0;
        end else begin
            if (ev_stop) m_busy = 0; else if (ev_start) m_busy = 1;
            m_ovf = (rx_push && rx_full) ? 1 : 0;
            if (ev_xfer_done) m_done = 1; else if (stat_rd) m_done = 0;
            if (ev_addr_nack) m_an = 1; else if (ev_start) m_an = 0;
            if (ev_data_nack) m_dn = 1; else if (ev_start) m_dn = 0;
            if (ev_arb_lost) m_arb = 1; else if (ev_start) m_arb = 0;
            m_rxq = rx_push ? 1 : 0;
            m_mb = (mst_busy_in && !ev_arb_lost) ? 1 : 0;
            if (addr_wr_sent) m_aw = 1; else if (ev_stop) m_aw = 0;
            m_odd = ((tx_push && tx_pop) || (tx_pop && !tx_push && m_cnt == 0)
                     || (tx_push && !tx_pop && m_cnt == 2)) ? 1 : 0;
            if (tx_push && !tx_pop && m_cnt < 2) begin
                m_cnt = m_cnt + 1; m_bypop = 0;
            end else if (tx_pop && !tx_push && m_cnt > 0) begin
                m_cnt = m_cnt - 1; m_bypop = 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        int code, txq, eirq;
        code = (m_cnt == 0) ? 0 : (m_cnt == 2) ? 3 : (m_bypop ? 2 : 1);
        txq  = (m_aw && m_cnt < 2) ? 1 : 0;
        eirq = ((ie_xfer && m_done) || (ie_nack && (m_dn || m_an)) || (ie_arb && m_arb)
                || (ie_rx && m_rxq) || (ie_tx && txq)) ? 1 : 0;
        chk("R1 reserved", int'(stat_word[15:11]), 0);
        chk("R2 bus busy", int'(stat_word[10]), m_busy);
        chk("R3 rx overflow", int'(stat_word[9]), m_ovf);
        chk("R4 transfer done", int'(stat_word[8]), m_done);
        chk("R5 nack/arb", int'({stat_word[7], stat_word[5], stat_word[4]}), m_dn*4 + m_arb*2 + m_an);
        chk("R6 master busy", int'(stat_word[6]), m_mb);
        chk("R7 rx request", int'(stat_word[3]), m_rxq);
        chk("R8 tx request", int'(stat_word[2]), txq);
        if (m_odd != 0) chk("R10 level kept", int'(stat_word[1:0]), code);
        else            chk("R9 level code", int'(stat_word[1:0]), code);
        chk("R11 irq", int'(irq), eirq);
    endtask

    task automatic clear_inputs();
        ev_start = 0; ev_stop = 0; ev_arb_lost = 0; ev_addr_nack = 0;
        ev_data_nack = 0; ev_xfer_done = 0; rx_push = 0; rx_full = 0;
        tx_push = 0; tx_pop = 0; addr_wr_sent = 0; stat_rd = 0;
    endtask

    // one cycle: compare at negedge, then drive the next inputs
    task automatic step(input bit psh, input bit pop);
        @(negedge clk);
        compare_all();
        clear_inputs();
        tx_push = psh; tx_pop = pop;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            compare_all();
        end
        rst_n = 1'b1;
        ie_tx = 1;
        addr_wr_sent = 1;
        // directed level walk: R9, R10
        step(1, 0); step(1, 0); step(1, 0); step(0, 1); step(1, 1);
        step(1, 0); step(0, 1); step(0, 1); step(0, 1); step(1, 1);
        step(1, 0); step(0, 1); step(0, 0); step(0, 0);
        // random traffic
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            compare_all();
            ev_start     = ($urandom_range(0, 9) == 0);
            ev_stop      = ($urandom_range(0, 11) == 0);
            ev_arb_lost  = ($urandom_range(0, 19) == 0);
            ev_addr_nack = ($urandom_range(0, 19) == 0);
            ev_data_nack = ($urandom_range(0, 19) == 0);
            ev_xfer_done = ($urandom_range(0, 9) == 0);
            rx_push      = ($urandom_range(0, 3) == 0);
            rx_full      = ($urandom_range(0, 2) == 0);
            tx_push      = ($urandom_range(0, 2) == 0);
            tx_pop       = ($urandom_range(0, 2) == 0);
            addr_wr_sent = ($urandom_range(0, 14) == 0);
            mst_busy_in  = ($urandom_range(0, 1) == 0);
            stat_rd      = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 15) == 0) begin
                ie_xfer = $urandom_range(0, 1); ie_nack = $urandom_range(0, 1);
                ie_arb  = $urandom_range(0, 1); ie_rx   = $urandom_range(0, 1);
                ie_tx   = $urandom_range(0, 1);
            end
        end
        @(negedge clk);
        compare_all();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule